// File: doc/BRIEF.md
# Four-Channel Switch-Selected Logic Conditioner

This block takes four single-bit logic signals and produces four conditioned outputs. A 4-bit mode value picks the processing. The modes cover plain routing, fan-out of one input, OR/AND combining, the inverted forms of these, conversion of input edges to short pulses, lengthening of input pulses, and a free-running low-rate pulser. A separate pair-swap control exchanges the inputs of each pair before any processing. The pairs are channel 0 with channel 1, and channel 2 with channel 3.

Leading edges always pass through the combinational path, so their timing is kept. Trailing edges of generated pulses are set by the single system clock. The extension length is a whole number of clock cycles. It is derived from the clock period parameter and a minimum extension in picoseconds. The pulser period and high time are derived the same way from a target frequency and a target width.

Top module: `sig_cond4`

## Requirements
- R1: While `rst_n` is low, all pulse-extension counters are held clear, so mode 6 with all inputs low gives `sig_out = 0000`. The pulser is also held at the start of its high phase, so mode 14 gives `1111`. After release, the first high phase lasts HIGH cycles.
- R2: With `swap_pairs = 1`, the working inputs are `w[0]=sig_in[1]`, `w[1]=sig_in[0]`, `w[2]=sig_in[3]` and `w[3]=sig_in[2]`. With `swap_pairs = 0`, `w = sig_in`. The swap applies in every mode.
- R3: Mode 0 gives `sig_out = w`. Mode 3 gives `sig_out = ~w`.
- R4: Mode 1 drives all four outputs with `w[1]`. Mode 4 drives all four with `~w[1]`.
- R5: Mode 2 gives out0=`w[0]`, out1=`w[0]|w[2]`, out2=`w[2]` and out3=`w[0]&w[2]`. Mode 5 applies the same map to `~w`.
- R6: In mode 6, a rising `w[i]` raises `sig_out[i]` with no clock delay. The output then stays high through EXT further clock cycles after the first edge that samples the new level, then falls. A falling input produces no pulse. EXT is ceil(EXT_MIN_PS / CLK_PERIOD_PS).
- R7: Mode 7 behaves like mode 6, but on falling edges of `w[i]`. A rising input produces no pulse.
- R8: Modes 8, 9 and 10 apply the maps of modes 0, 1 and 2 to stretched inputs. A stretched input rises with `w[i]` at once. After `w[i]` falls, it stays high until the next clock edge and for EXT cycles after that edge.
- R9: Mode 14 drives all outputs with a pulse train. Its period is PER = floor(1e12 / (PULSE_HZ * CLK_PERIOD_PS)) cycles and its high time is HIGH = ceil(PULSE_WIDTH_PS / CLK_PERIOD_PS) cycles. Mode 15 is the same train inverted.
- R10: Modes 11, 12 and 13 drive all outputs low, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 4 | Processing mode, 0 to 15 |
| swap_pairs | input | 1 | Exchange inputs 0/1 and 2/3 before processing |
| sig_in | input | 4 | Logic inputs |
| sig_out | output | 4 | Conditioned outputs |

## Verification
The sharpest corners are the lengths of the extended pulses. The bench counts samples taken between clock edges after each driven input edge. An extension counter that is off by one cycle, or that loses the hold term between the input edge and the next clock edge, gives a count other than EXT+1 or a dropped leading sample.

Edge modes are also driven with the opposite polarity. A detector wired to the wrong edge would then produce a spurious pulse.

The swap is exercised inside the combining and stretch modes, not only in routing. A swap applied after the mode map, or with the pairs crossed the wrong way, changes which output carries the OR and the AND.

The pulser is measured over a full period and a full high phase in both polarities, and again right after reset. A wrap at PER instead of PER-1, or a restart outside the high phase, shows up as a wrong cycle count.

// File: rtl/sc4_pkg.sv
package sc4_pkg;

  typedef enum logic [1:0] {
    EXT_RISE    = 2'd0,
    EXT_FALL    = 2'd1,
    EXT_STRETCH = 2'd2
  } ext_kind_e;

  // Whole cycles covering a minimum duration (rounded up).
  function automatic int ceil_cycles(int unsigned dur_ps, int unsigned period_ps);
    return int'((dur_ps + period_ps - 1) / period_ps);
  endfunction

  // Cycles in one period of a target frequency (rounded down).
  function automatic int period_cycles(int unsigned hz, int unsigned period_ps);
    longint unsigned num;
    longint unsigned den;
    num = 64'd1_000_000_000_000;
    den = longint'(hz) * longint'(period_ps);
    return int'(num / den);
  endfunction

  // Output map shared by the routing, combining and stretch modes.
  function automatic logic [3:0] route4(logic [1:0] sel, logic [3:0] v);
    case (sel)
      2'd0:    return v;
      2'd1:    return {4{v[1]}};
      2'd2:    return {v[0] & v[2], v[2], v[0] | v[2], v[0]};
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/sc4_edge_ext.sv
module sc4_edge_ext
  import sc4_pkg::*;
#(
  parameter int EXT = 2,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  ext_kind_e     kind,
  output logic          dout,
  output logic [CW-1:0] cnt_o
);
  logic          d_q;
  logic [CW-1:0] cnt_q;
  logic          rise_now, fall_now, trig, busy;

  assign rise_now = din & ~d_q;
  assign fall_now = ~din & d_q;
  assign trig     = (kind == EXT_RISE) ? rise_now : fall_now;
  assign busy     = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      d_q <= din;
      if (trig)
        cnt_q <= CW'(EXT);
      else if (busy)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    case (kind)
      EXT_RISE: dout = busy | rise_now;
      EXT_FALL: dout = busy | fall_now;
      default:  dout = busy | din | d_q;
    endcase
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sc4_pulser.sv
module sc4_pulser #(
  parameter int PER  = 17636,
  parameter int HIGH = 9
) (
  input  logic clk,
  input  logic rst_n,
  output logic pls
);
  localparam int PW = (PER > 2) ? $clog2(PER) : 1;

  logic [PW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= '0;
    else if (pc_q == PW'(PER - 1))
      pc_q <= '0;
    else
      pc_q <= pc_q + 1'b1;
  end

  assign pls = (pc_q < PW'(HIGH));
endmodule

// File: rtl/sig_cond4.sv
module sig_cond4
  import sc4_pkg::*;
#(
  parameter int CLK_PERIOD_PS  = 7000,
  parameter int EXT_MIN_PS     = 14000,
  parameter int PULSE_HZ       = 8100,
  parameter int PULSE_WIDTH_PS = 60000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_sel,
  input  logic       swap_pairs,
  input  logic [3:0] sig_in,
  output logic [3:0] sig_out
);
  localparam int EXT_CYC  = ceil_cycles(EXT_MIN_PS, CLK_PERIOD_PS);
  localparam int PER_CYC  = period_cycles(PULSE_HZ, CLK_PERIOD_PS);
  localparam int HIGH_CYC = ceil_cycles(PULSE_WIDTH_PS, CLK_PERIOD_PS);
  localparam int CW       = $clog2(EXT_CYC + 1);

  // Named internal events for the checker.
  logic [3:0]          w;
  logic [3:0]          ext;
  logic [3:0][CW-1:0]  ext_cnt;
  logic                pls;
  ext_kind_e           kind;

  assign w = swap_pairs ? {sig_in[2], sig_in[3], sig_in[0], sig_in[1]} : sig_in;

  always_comb begin
    case (mode_sel)
      4'd6:    kind = EXT_RISE;
      4'd7:    kind = EXT_FALL;
      default: kind = EXT_STRETCH;
    endcase
  end

  for (genvar i = 0; i < 4; i++) begin : g_ch
    sc4_edge_ext #(.EXT(EXT_CYC), .CW(CW)) u_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (w[i]),
      .kind  (kind),
      .dout  (ext[i]),
      .cnt_o (ext_cnt[i])
    );
  end

  sc4_pulser #(.PER(PER_CYC), .HIGH(HIGH_CYC)) u_pulser (
    .clk   (clk),
    .rst_n (rst_n),
    .pls   (pls)
  );

  always_comb begin
    case (mode_sel)
      4'd0, 4'd1, 4'd2:   sig_out = route4(mode_sel[1:0], w);
      4'd3:               sig_out = ~route4(2'd0, w);
      4'd4:               sig_out = ~route4(2'd1, w);
      4'd5:               sig_out = route4(2'd2, ~w);
      4'd6, 4'd7:         sig_out = ext;
      4'd8, 4'd9, 4'd10:  sig_out = route4(mode_sel[1:0], ext);
      4'd14:              sig_out = {4{pls}};
      4'd15:              sig_out = {4{~pls}};
      default:            sig_out = 4'b0000;
    endcase
  end
endmodule

// File: rtl/sig_cond4_chk.sv
module sig_cond4_chk #(
  parameter int EXT = 2,
  parameter int PER = 17636,
  parameter int CW  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         mode_sel,
  input logic               swap_pairs,
  input logic [3:0]         sig_in,
  input logic [3:0]         sig_out,
  input logic               pls,
  input logic [3:0][CW-1:0] ext_cnt
);
  logic        pls_prev;
  logic        seen_rise;
  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_prev  <= 1'b0;
      seen_rise <= 1'b0;
      gap       <= 0;
    end else begin
      pls_prev <= pls;
      if (pls && !pls_prev) begin
        seen_rise <= 1'b1;
        gap       <= 0;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  p_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pls && !pls_prev && seen_rise) |-> (gap == PER - 1));

  p_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel inside {4'd11, 4'd12, 4'd13}) |-> (sig_out == 4'b0000));

  p_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd0 && !swap_pairs) |-> (sig_out == sig_in));

  p_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd0 && swap_pairs) |->
      (sig_out == {sig_in[2], sig_in[3], sig_in[0], sig_in[1]}));

  p_fan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd1 && !swap_pairs) |-> (sig_out == {4{sig_in[1]}}));

  p_stretch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 4'd8 && $past(mode_sel) == 4'd8 && !swap_pairs &&
     !$past(swap_pairs) && $fell(sig_in[0])) |-> sig_out[0]);

  for (genvar i = 0; i < 4; i++) begin : g_cnt
    p_ext_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_cnt[i] <= CW'(EXT));
  end
endmodule

bind sig_cond4 sig_cond4_chk #(.EXT(EXT_CYC), .PER(PER_CYC), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .swap_pairs (swap_pairs),
  .sig_in     (sig_in),
  .sig_out    (sig_out),
  .pls        (pls),
  .ext_cnt    (ext_cnt)
);

// File: tb/sig_cond4_test.sv
module sig_cond4_test;
  localparam int T_PS   = 8000;
  localparam int B_EXT  = (14000 + T_PS - 1) / T_PS;   // 2
  localparam int B_PER  = 1_000_000_000 / (1000 * T_PS); // 125 cycles at 1 MHz
  localparam int B_HIGH = (60000 + T_PS - 1) / T_PS;   // 8

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_sel = 4'd0;
  logic       swap_pairs = 1'b0;
  logic [3:0] sig_in = 4'b0000;
  logic [3:0] sig_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sig_cond4 #(
    .CLK_PERIOD_PS(T_PS), .EXT_MIN_PS(14000),
    .PULSE_HZ(1_000_000), .PULSE_WIDTH_PS(60000)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .swap_pairs(swap_pairs), .sig_in(sig_in), .sig_out(sig_out)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [3:0] ref_comb(logic [3:0] m, logic sw, logic [3:0] x);
    logic [3:0] v;
    logic a, b, c, d;
    v = x;
    if (sw) begin
      v[0] = x[1]; v[1] = x[0]; v[2] = x[3]; v[3] = x[2];
    end
    a = v[0]; b = v[1]; c = v[2]; d = v[3];
    case (m)
      4'd0: return {d, c, b, a};
      4'd1: return b ? 4'b1111 : 4'b0000;
      4'd2: return {a && c, c, a || c, a};
      4'd3: return {!d, !c, !b, !a};
      4'd4: return b ? 4'b0000 : 4'b1111;
      4'd5: return {!a && !c, !c, !a || !c, !a};
      default: return 4'bxxxx;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Count consecutive samples where sig_out equals pat, starting now.
  task automatic count_eq(logic [3:0] pat, output int n);
    n = 0;
    while (sig_out == pat && n < 1000) begin
      n++;
      step();
    end
  endtask

  task automatic t_reset();
    mode_sel = 4'd6; sig_in = 4'b0000;
    repeat (3) step();
    chk("R1 edge idle in reset", sig_out, 4'b0000);
    mode_sel = 4'd14;
    #1;
    chk("R1 pulser held high in reset", sig_out, 4'b1111);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    begin
      int n;
      count_eq(4'b1111, n);
      chk("R1 first high phase", n, B_HIGH);
    end
  endtask

  task automatic t_comb();
    for (int m = 0; m < 6; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 16; p++) begin
          @(negedge clk);
          mode_sel = 4'(m); swap_pairs = 1'(s); sig_in = 4'(p);
          #1;
          case (m)
            0, 3: chk(s ? "R3 R2 route" : "R3 route", sig_out, ref_comb(4'(m), 1'(s), 4'(p)));
            1, 4: chk(s ? "R4 R2 fan" : "R4 fan", sig_out, ref_comb(4'(m), 1'(s), 4'(p)));
            default: chk(s ? "R5 R2 combine" : "R5 combine", sig_out, ref_comb(4'(m), 1'(s), 4'(p)));
          endcase
        end
      end
    end
    swap_pairs = 1'b0;
  endtask

  task automatic t_blank();
    for (int m = 11; m < 14; m++) begin
      @(negedge clk);
      mode_sel = 4'(m); sig_in = 4'b1111;
      #1;
      chk("R10 blank high in", sig_out, 0);
      sig_in = 4'b0101;
      #1;
      chk("R10 blank mixed in", sig_out, 0);
    end
  endtask

  task automatic t_rise();
    int n;
    @(negedge clk);
    mode_sel = 4'd6; sig_in = 4'b0000;
    repeat (4) step();
    chk("R6 idle", sig_out, 0);
    @(negedge clk);
    sig_in = 4'b1111;
    #1;
    count_eq(4'b1111, n);
    chk("R6 rise pulse length", n, B_EXT + 1);
    repeat (3) step();
    chk("R6 low while input held", sig_out, 0);
    @(negedge clk);
    sig_in = 4'b0000;
    #1;
    chk("R6 no pulse on fall", sig_out, 0);
    repeat (3) begin
      step();
      chk("R6 no pulse after fall", sig_out, 0);
    end
  endtask

  task automatic t_fall();
    int n;
    @(negedge clk);
    sig_in = 4'b1111; mode_sel = 4'd7;
    repeat (4) step();
    chk("R7 idle high input", sig_out, 0);
    @(negedge clk);
    sig_in = 4'b0000;
    #1;
    count_eq(4'b1111, n);
    chk("R7 fall pulse length", n, B_EXT + 1);
    @(negedge clk);
    sig_in = 4'b1111;
    #1;
    chk("R7 no pulse on rise", sig_out, 0);
    step();
    chk("R7 no pulse after rise", sig_out, 0);
  endtask

  task automatic t_stretch();
    int n;
    @(negedge clk);
    sig_in = 4'b0000; mode_sel = 4'd8; swap_pairs = 1'b0;
    repeat (4) step();
    chk("R8 idle", sig_out, 0);
    @(negedge clk);
    sig_in = 4'b0001;
    #1;
    chk("R8 leading edge immediate", sig_out, 4'b0001);
    repeat (4) step();
    @(negedge clk);
    sig_in = 4'b0000;
    #1;
    count_eq(4'b0001, n);
    chk("R8 stretch length", n, B_EXT + 1);
    chk("R8 back low", sig_out, 0);
    // Combining mode on stretched, swapped inputs.
    @(negedge clk);
    mode_sel = 4'd10; swap_pairs = 1'b1; sig_in = 4'b0000;
    repeat (4) step();
    @(negedge clk);
    sig_in = 4'b0010;
    #1;
    chk("R8 R2 combine stretched", sig_out, 4'b0011);
    repeat (3) step();
    @(negedge clk);
    sig_in = 4'b0000;
    #1;
    count_eq(4'b0011, n);
    chk("R8 R2 combine stretch length", n, B_EXT + 1);
    swap_pairs = 1'b0;
  endtask

  task automatic t_pulser();
    int n, k;
    @(negedge clk);
    mode_sel = 4'd14; sig_in = 4'b1010;
    #1;
    k = 0;
    while (sig_out != 4'b0000 && k < 1000) begin k++; step(); end
    k = 0;
    while (sig_out != 4'b1111 && k < 1000) begin k++; step(); end
    count_eq(4'b1111, n);
    chk("R9 high time", n, B_HIGH);
    count_eq(4'b0000, n);
    chk("R9 low time", n, B_PER - B_HIGH);
    @(negedge clk);
    mode_sel = 4'd15;
    #1;
    k = 0;
    while (sig_out != 4'b1111 && k < 1000) begin k++; step(); end
    k = 0;
    while (sig_out != 4'b0000 && k < 1000) begin k++; step(); end
    count_eq(4'b0000, n);
    chk("R9 inverted low time", n, B_HIGH);
    count_eq(4'b1111, n);
    chk("R9 inverted high time", n, B_PER - B_HIGH);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_comb();
    t_blank();
    t_rise();
    t_fall();
    t_stretch();
    t_pulser();
    summary();
    $finish;
  end
endmodule